// File: doc/BRIEF.md
# Addressed SPI Command Decoder for a Four-Channel Trim Block

This block is the serial control front end of a trim device with four channels. Two channels are potentiometers, each holding a 6-bit wiper position. The other two are comparator channels, each holding a 6-bit control word. An SPI host opens a frame by pulling chip select low. It then sends an identification byte, which carries a fixed device-type code and two address bits. Those two bits must match the board strap pins. Only after a match does the block accept an instruction byte. That byte names an operation, one of four data registers and one of the four channels.

Each channel has one working register, which drives the analog side, and a bank of four 8-bit data registers. The data registers start at zero and stand in for non-volatile storage. Operations can read or write the working register, read or write a data register, and copy in either direction between the two. Reads return one byte on SDO in the byte that follows the instruction. Writes take their value from that byte. The working registers of the potentiometer channels appear on one output bus and those of the comparator channels on another.

The SPI pins are sampled in the core clock domain through a synchronizer. The serial clock must therefore be several core clocks slower than the core clock.

Top module: `spi_trim_cmd_dec`

## Requirements
- R1: The first byte received after chip select falls is the identification byte. If its bits 7:4 differ from 0101, or its bits 3:2 are not 00, the rest of the frame is ignored: no register changes and SDO stays disabled.
- R2: Bits 1:0 of the identification byte must equal `addr_i[1:0]`. On a mismatch, every later bit is ignored until chip select returns high.
- R3: The second byte is the instruction byte. Bits 7:4 are the opcode, bits 3:2 the data-register index and bits 1:0 the channel. Channels 0 and 1 are potentiometers and channels 2 and 3 are comparators. A command affects only the channel and index it names.
- R4: Opcode 1010 writes bits 5:0 of the third byte into the named working register and drops bits 7:6. Opcode 1001 returns that register in the third byte as {00, value}.
- R5: Opcode 1100 stores the full third byte in data register [channel][index]. Opcode 1011 returns that data register in the third byte.
- R6: Opcode 1101 loads bits 5:0 of data register [channel][index] into the working register. Opcode 1110 stores the working register, zero-extended to 8 bits, into that data register. Both act when the instruction byte completes.
- R7: Every other opcode leaves all registers unchanged and never enables SDO.
- R8: MOSI is sampled on rising SCK, and read data is sent MSB first with each new bit placed after a falling SCK. `sdo_oe_o` is high only during the read-data byte while chip select is low.
- R9: If chip select rises before a write byte is complete, the partial byte is discarded. The next frame starts over with an identification byte.
- R10: After reset, all working registers and all data registers are zero and `sdo_oe_o` is low.
- R11: `wiper_pos_o` is {channel 1, channel 0}, 6 bits each. `cmp_ctrl_o` is {channel 3, channel 2}, 6 bits each. In each comparator word, bit 0 powers the comparator, bit 1 enables its output buffer, bit 2 latches its output, and bits 5:3 are free user bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI serial clock |
| cs_n_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from the host |
| addr_i | input | 2 | Strap pins compared with the identification byte bits 1:0 |
| sdo_o | output | 1 | Serial read data; 0 while not enabled |
| sdo_oe_o | output | 1 | Output enable for the SDO pad driver |
| wiper_pos_o | output | 12 | Wiper positions of channels 1 and 0 |
| cmp_ctrl_o | output | 12 | Control words of comparator channels 3 and 2 |

## Verification
The assertions assume the following:
- SCK, chip select and MOSI are free of glitches.
- Each level of SCK lasts at least several core clocks, so the synchronizer catches every edge.
- Chip select stays high for at least four core clocks between frames, which lets the output-enable property look back over that span.

The stimulus keeps within these limits by driving every pin on core-clock boundaries. SCK half periods are eight core clocks long. After each frame, chip select is held high for thirty-two clocks. The address straps change only while chip select is high.

// File: rtl/spi_trim_pkg.sv
package spi_trim_pkg;

    typedef enum logic [2:0] {
        ST_ID    = 3'd0,
        ST_INSTR = 3'd1,
        ST_WR    = 3'd2,
        ST_RD    = 3'd3,
        ST_HOLD  = 3'd4
    } cmd_st_e;

    localparam logic [3:0] OP_RD_WORK  = 4'b1001;
    localparam logic [3:0] OP_WR_WORK  = 4'b1010;
    localparam logic [3:0] OP_RD_DR    = 4'b1011;
    localparam logic [3:0] OP_WR_DR    = 4'b1100;
    localparam logic [3:0] OP_DR2WORK  = 4'b1101;
    localparam logic [3:0] OP_WORK2DR  = 4'b1110;

    localparam logic [3:0] DEV_TYPE_DEFAULT = 4'b0101;

endpackage

// File: rtl/spi_trim_in_sync.sv
module spi_trim_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic cs_act_o,
    output logic mosi_o
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] csn;
        logic [STAGES-1:0] mosi;
        logic              sck_last;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.sck      = {q.sck[STAGES-2:0], sck_i};
        d.csn      = {q.csn[STAGES-2:0], cs_n_i};
        d.mosi     = {q.mosi[STAGES-2:0], mosi_i};
        d.sck_last = q.sck[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sck      <= '0;
            q.csn      <= '1;
            q.mosi     <= '0;
            q.sck_last <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sck_rise_o = q.sck[TOP] & ~q.sck_last;
    assign sck_fall_o = ~q.sck[TOP] & q.sck_last;
    assign cs_act_o   = ~q.csn[TOP];
    assign mosi_o     = q.mosi[TOP];

endmodule

// File: rtl/spi_trim_framer.sv
module spi_trim_framer #(
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_act_i,
    input  logic                        sck_rise_i,
    input  logic                        mosi_i,
    output logic                        byte_done_o,
    output logic [DATA_W-1:0]           byte_o,
    output logic [$clog2(DATA_W)-1:0]   bit_cnt_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } frm_t;

    frm_t q, d;

    always_comb begin
        d = q;
        if (!cs_act_i) begin
            d = '0;
        end else if (sck_rise_i) begin
            d.sh  = {q.sh[DATA_W-2:0], mosi_i};
            d.cnt = (q.cnt == LAST) ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_done_o = cs_act_i & sck_rise_i & (q.cnt == LAST);
    assign byte_o      = {q.sh[DATA_W-2:0], mosi_i};
    assign bit_cnt_o   = q.cnt;

endmodule

// File: rtl/spi_trim_reg_bank.sv
module spi_trim_reg_bank #(
    parameter int CHANNELS = 4,
    parameter int DR_DEPTH = 4,
    parameter int DATA_W   = 8,
    parameter int WORK_W   = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(CHANNELS)-1:0]   chan_i,
    input  logic [$clog2(DR_DEPTH)-1:0]   idx_i,
    input  logic [DATA_W-1:0]             wdata_i,
    input  logic                          wr_work_i,
    input  logic                          wr_dr_i,
    input  logic                          cp_dr2work_i,
    input  logic                          cp_work2dr_i,
    output logic [WORK_W-1:0]             rd_work_o,
    output logic [DATA_W-1:0]             rd_dr_o,
    output logic [CHANNELS*WORK_W-1:0]    work_all_o
);
    typedef struct packed {
        logic [CHANNELS-1:0][WORK_W-1:0]                work;
        logic [CHANNELS-1:0][DR_DEPTH-1:0][DATA_W-1:0] dr;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        if (wr_work_i)    d.work[chan_i]       = wdata_i[WORK_W-1:0];
        if (wr_dr_i)      d.dr[chan_i][idx_i]  = wdata_i;
        if (cp_dr2work_i) d.work[chan_i]       = q.dr[chan_i][idx_i][WORK_W-1:0];
        if (cp_work2dr_i) d.dr[chan_i][idx_i]  = DATA_W'(q.work[chan_i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_work_o  = q.work[chan_i];
    assign rd_dr_o    = q.dr[chan_i][idx_i];
    assign work_all_o = q.work;

endmodule

// File: rtl/spi_trim_cmd_dec.sv
module spi_trim_cmd_dec
    import spi_trim_pkg::*;
#(
    parameter int          CHANNELS    = 4,
    parameter int          POT_CH      = 2,
    parameter int          DR_DEPTH    = 4,
    parameter int          DATA_W      = 8,
    parameter int          WORK_W      = 6,
    parameter int          ADDR_W      = 2,
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  DEV_TYPE    = DEV_TYPE_DEFAULT
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  sck_i,
    input  logic                                  cs_n_i,
    input  logic                                  mosi_i,
    input  logic [ADDR_W-1:0]                     addr_i,
    output logic                                  sdo_o,
    output logic                                  sdo_oe_o,
    output logic [POT_CH*WORK_W-1:0]              wiper_pos_o,
    output logic [(CHANNELS-POT_CH)*WORK_W-1:0]   cmp_ctrl_o
);
    localparam int CMP_CH = CHANNELS - POT_CH;
    localparam int CH_W   = $clog2(CHANNELS);
    localparam int IDX_W  = $clog2(DR_DEPTH);
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int OPC_LO = DATA_W - 4;
    localparam int IDX_LO = CH_W;

    typedef struct packed {
        cmd_st_e           state;
        logic [3:0]        opc;
        logic [IDX_W-1:0]  idx;
        logic [CH_W-1:0]   chan;
        logic [DATA_W-1:0] tx;
        logic              oe;
    } ctl_t;

    ctl_t q, d;

    logic                      sck_rise, sck_fall, cs_act, mosi_s;
    logic                      byte_done;
    logic [DATA_W-1:0]         byte_val;
    logic [CNT_W-1:0]          bit_cnt;
    logic [CH_W-1:0]           cmd_chan;
    logic [IDX_W-1:0]          cmd_idx;
    logic                      wr_work, wr_dr, cp_d2w, cp_w2d;
    logic [WORK_W-1:0]         rd_work;
    logic [DATA_W-1:0]         rd_dr;
    logic [CHANNELS*WORK_W-1:0] work_all;
    cmd_st_e                   state_q;

    spi_trim_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck_i),
        .cs_n_i     (cs_n_i),
        .mosi_i     (mosi_i),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .cs_act_o   (cs_act),
        .mosi_o     (mosi_s)
    );

    spi_trim_framer #(.DATA_W(DATA_W)) frm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_act_i    (cs_act),
        .sck_rise_i  (sck_rise),
        .mosi_i      (mosi_s),
        .byte_done_o (byte_done),
        .byte_o      (byte_val),
        .bit_cnt_o   (bit_cnt)
    );

    // Address fields come straight from the byte while it is the instruction.
    always_comb begin
        if (q.state == ST_INSTR) begin
            cmd_chan = byte_val[CH_W-1:0];
            cmd_idx  = byte_val[IDX_LO+IDX_W-1:IDX_LO];
        end else begin
            cmd_chan = q.chan;
            cmd_idx  = q.idx;
        end
    end

    spi_trim_reg_bank #(
        .CHANNELS (CHANNELS),
        .DR_DEPTH (DR_DEPTH),
        .DATA_W   (DATA_W),
        .WORK_W   (WORK_W)
    ) bank_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_i       (cmd_chan),
        .idx_i        (cmd_idx),
        .wdata_i      (byte_val),
        .wr_work_i    (wr_work),
        .wr_dr_i      (wr_dr),
        .cp_dr2work_i (cp_d2w),
        .cp_work2dr_i (cp_w2d),
        .rd_work_o    (rd_work),
        .rd_dr_o      (rd_dr),
        .work_all_o   (work_all)
    );

    always_comb begin
        d       = q;
        wr_work = 1'b0;
        wr_dr   = 1'b0;
        cp_d2w  = 1'b0;
        cp_w2d  = 1'b0;
        if (!cs_act) begin
            d.state = ST_ID;
            d.tx    = '0;
        end else begin
            if (sck_fall && (bit_cnt != '0) && (q.state == ST_RD))
                d.tx = {q.tx[DATA_W-2:0], 1'b0};
            if (byte_done) begin
                unique case (q.state)
                    ST_ID: begin
                        if ((byte_val[DATA_W-1:OPC_LO] == DEV_TYPE) &&
                            (byte_val[OPC_LO-1:ADDR_W] == '0) &&
                            (byte_val[ADDR_W-1:0] == addr_i))
                            d.state = ST_INSTR;
                        else
                            d.state = ST_HOLD;
                    end
                    ST_INSTR: begin
                        d.opc  = byte_val[DATA_W-1:OPC_LO];
                        d.idx  = cmd_idx;
                        d.chan = cmd_chan;
                        d.state = ST_HOLD;
                        case (byte_val[DATA_W-1:OPC_LO])
                            OP_RD_WORK: begin
                                d.tx    = DATA_W'(rd_work);
                                d.state = ST_RD;
                            end
                            OP_RD_DR: begin
                                d.tx    = rd_dr;
                                d.state = ST_RD;
                            end
                            OP_WR_WORK, OP_WR_DR: d.state = ST_WR;
                            OP_DR2WORK: cp_d2w = 1'b1;
                            OP_WORK2DR: cp_w2d = 1'b1;
                            default: ;
                        endcase
                    end
                    ST_WR: begin
                        if (q.opc == OP_WR_WORK) wr_work = 1'b1;
                        else                     wr_dr   = 1'b1;
                        d.state = ST_HOLD;
                    end
                    ST_RD:   d.state = ST_HOLD;
                    default: d.state = ST_HOLD;
                endcase
            end
        end
        d.oe = cs_act && (d.state == ST_RD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_ID;
        end else begin
            q <= d;
        end
    end

    assign state_q  = q.state;
    assign sdo_o    = q.oe & q.tx[DATA_W-1];
    assign sdo_oe_o = q.oe;

    generate
        for (genvar p = 0; p < POT_CH; p++) begin : g_pot
            assign wiper_pos_o[p*WORK_W +: WORK_W] = work_all[p*WORK_W +: WORK_W];
        end
        for (genvar c = 0; c < CMP_CH; c++) begin : g_cmp
            assign cmp_ctrl_o[c*WORK_W +: WORK_W] = work_all[(POT_CH+c)*WORK_W +: WORK_W];
        end
    endgenerate

endmodule

// File: rtl/spi_trim_cmd_dec_chk.sv
module spi_trim_cmd_dec_chk
    import spi_trim_pkg::*;
#(
    parameter int WP_W = 12,
    parameter int CC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n_i,
    input  logic            cs_act_i,
    input  logic            sdo_oe_i,
    input  cmd_st_e         state_i,
    input  logic [3:0]      strobe_i,
    input  logic [WP_W-1:0] wiper_i,
    input  logic [CC_W-1:0] cmp_i
);
    logic [2:0] settle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                settle_q <= '0;
        else if (settle_q != 3'd4) settle_q <= settle_q + 3'd1;
    end

    // R8: chip select high long enough through the synchronizer silences SDO
    assert_sdo_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q == 3'd4 && cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3))
        |-> !sdo_oe_i);

    // R8: the output driver is only enabled in the read-data byte
    assert_oe_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_i |-> (state_i == ST_RD));

    // R1: a frame always opens in the identification state
    assert_id_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_act_i) |-> (state_i == ST_ID));

    // R2: once a frame is abandoned it cannot reach a command state
    assert_hold_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_HOLD && cs_act_i) |=>
        (state_i != ST_INSTR && state_i != ST_WR && state_i != ST_RD));

    // R7: at most one register action per cycle
    assert_single_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_i));

    // R9: register actions happen only inside an open frame
    assert_action_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i != 4'b0) |-> cs_act_i);

    // R9: between frames the exported registers hold
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act_i |=> ($stable(wiper_i) && $stable(cmp_i)));

endmodule

bind spi_trim_cmd_dec spi_trim_cmd_dec_chk #(
    .WP_W (POT_CH*WORK_W),
    .CC_W ((CHANNELS-POT_CH)*WORK_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_i   (cs_n_i),
    .cs_act_i (cs_act),
    .sdo_oe_i (sdo_oe_o),
    .state_i  (state_q),
    .strobe_i ({wr_work, wr_dr, cp_d2w, cp_w2d}),
    .wiper_i  (wiper_pos_o),
    .cmp_i    (cmp_ctrl_o)
);

// File: tb/spi_trim_cmd_dec_tb_top.sv
`timescale 1ns/1ps
module spi_trim_cmd_dec_tb_top;

    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic [1:0]  addr = 2'b01;
    logic        sdo, sdo_oe;
    logic [11:0] wiper_pos, cmp_ctrl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_trim_cmd_dec dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_i       (sck),
        .cs_n_i      (cs_n),
        .mosi_i      (mosi),
        .addr_i      (addr),
        .sdo_o       (sdo),
        .sdo_oe_o    (sdo_oe),
        .wiper_pos_o (wiper_pos),
        .cmp_ctrl_o  (cmp_ctrl)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] id_byte(input logic [1:0] a);
        return {4'b0101, 2'b00, a};
    endfunction

    function automatic logic [7:0] ins(input logic [3:0] op, input logic [1:0] idx, input logic [1:0] ch);
        return {op, idx, ch};
    endfunction

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            wait_clk(HP);
            rx[i] = sdo;
            sck = 1'b1;
            wait_clk(HP);
            sck = 1'b0;
        end
    endtask

    task automatic frame_open();
        cs_n = 1'b0;
        wait_clk(HP);
    endtask

    task automatic frame_close();
        wait_clk(HP);
        cs_n = 1'b1;
        wait_clk(4 * HP);
    endtask

    task automatic cmd(input logic [7:0] id, input logic [7:0] instr,
                       input logic [7:0] data, output logic [7:0] rx);
        logic [7:0] junk;
        frame_open();
        xfer(id, 8, junk);
        xfer(instr, 8, junk);
        xfer(data, 8, rx);
        frame_close();
    endtask

    task automatic t_reset();
        logic [7:0] rx;
        check("R10 wiper after reset", 32'(wiper_pos), 32'h0);
        check("R10 comparator after reset", 32'(cmp_ctrl), 32'h0);
        check("R10 sdo_oe after reset", 32'(sdo_oe), 32'h0);
        cmd(id_byte(2'b01), ins(4'b1011, 2'd0, 2'd3), 8'h00, rx);
        check("R10 data register ch3 idx0 zero", 32'(rx), 32'h0);
        cmd(id_byte(2'b01), ins(4'b1001, 2'd0, 2'd2), 8'h00, rx);
        check("R10 working register ch2 zero", 32'(rx), 32'h0);
    endtask

    task automatic t_wiper();
        logic [7:0] rx;
        cmd(id_byte(2'b01), ins(4'b1010, 2'd0, 2'd0), 8'h2A, rx);
        cmd(id_byte(2'b01), ins(4'b1010, 2'd0, 2'd1), 8'hFF, rx);
        check("R4 R11 wiper bus after writes", 32'(wiper_pos), 32'hFEA);
        cmd(id_byte(2'b01), ins(4'b1001, 2'd0, 2'd1), 8'h00, rx);
        check("R4 read ch1 upper bits zero", 32'(rx), 32'h3F);
        cmd(id_byte(2'b01), ins(4'b1001, 2'd0, 2'd0), 8'h00, rx);
        check("R4 R8 read ch0 msb first", 32'(rx), 32'h2A);
    endtask

    task automatic t_cmp();
        logic [7:0] rx;
        cmd(id_byte(2'b01), ins(4'b1010, 2'd0, 2'd2), 8'h05, rx);
        cmd(id_byte(2'b01), ins(4'b1010, 2'd0, 2'd3), 8'hC7, rx);
        check("R11 comparator bus", 32'(cmp_ctrl), 32'h1C5);
        check("R11 ch2 power bit0", 32'(cmp_ctrl[0]), 32'h1);
        check("R11 ch2 buffer bit1", 32'(cmp_ctrl[1]), 32'h0);
        check("R11 ch2 latch bit2", 32'(cmp_ctrl[2]), 32'h1);
        check("R3 pot channels untouched", 32'(wiper_pos), 32'hFEA);
        cmd(id_byte(2'b01), ins(4'b1001, 2'd0, 2'd3), 8'h00, rx);
        check("R4 ch3 read masked", 32'(rx), 32'h07);
    endtask

    task automatic t_dr();
        logic [7:0] rx;
        cmd(id_byte(2'b01), ins(4'b1100, 2'd3, 2'd2), 8'hA5, rx);
        cmd(id_byte(2'b01), ins(4'b1011, 2'd3, 2'd2), 8'h00, rx);
        check("R5 data register full byte", 32'(rx), 32'hA5);
        cmd(id_byte(2'b01), ins(4'b1011, 2'd2, 2'd2), 8'h00, rx);
        check("R3 other index untouched", 32'(rx), 32'h00);
        cmd(id_byte(2'b01), ins(4'b1011, 2'd3, 2'd3), 8'h00, rx);
        check("R3 other channel untouched", 32'(rx), 32'h00);
        check("R5 working regs untouched", 32'(cmp_ctrl), 32'h1C5);
    endtask

    task automatic t_copy();
        logic [7:0] rx;
        cmd(id_byte(2'b01), ins(4'b1100, 2'd1, 2'd0), 8'hF1, rx);
        check("R5 dr write leaves wiper", 32'(wiper_pos), 32'hFEA);
        cmd(id_byte(2'b01), ins(4'b1101, 2'd1, 2'd0), 8'h00, rx);
        check("R6 copy dr to working", 32'(wiper_pos), 32'hFF1);
        cmd(id_byte(2'b01), ins(4'b1110, 2'd2, 2'd1), 8'h00, rx);
        cmd(id_byte(2'b01), ins(4'b1011, 2'd2, 2'd1), 8'h00, rx);
        check("R6 copy working to dr", 32'(rx), 32'h3F);
    endtask

    task automatic t_bad_id();
        logic [7:0] rx;
        logic [7:0] junk;
        cmd(8'h65, ins(4'b1010, 2'd0, 2'd0), 8'h00, rx);
        check("R1 wrong type ignored", 32'(wiper_pos), 32'hFF1);
        cmd(8'h5D, ins(4'b1010, 2'd0, 2'd0), 8'h00, rx);
        check("R1 nonzero bits 3:2 ignored", 32'(wiper_pos), 32'hFF1);
        frame_open();
        xfer(8'h45, 8, junk);
        xfer(ins(4'b1001, 2'd0, 2'd0), 8, junk);
        wait_clk(2);
        check("R1 no sdo after bad id", 32'(sdo_oe), 32'h0);
        xfer(8'h00, 8, rx);
        frame_close();
        check("R1 no read data after bad id", 32'(rx), 32'h0);
    endtask

    task automatic t_addr();
        logic [7:0] rx;
        addr = 2'b10;
        wait_clk(4);
        cmd(id_byte(2'b01), ins(4'b1010, 2'd0, 2'd0), 8'h00, rx);
        check("R2 address mismatch ignored", 32'(wiper_pos), 32'hFF1);
        cmd(id_byte(2'b10), ins(4'b1010, 2'd0, 2'd0), 8'h0C, rx);
        check("R2 address match accepted", 32'(wiper_pos), 32'hFCC);
        addr = 2'b01;
        wait_clk(4);
    endtask

    task automatic t_opcode();
        logic [7:0] rx;
        cmd(id_byte(2'b01), ins(4'b0000, 2'd0, 2'd0), 8'h00, rx);
        cmd(id_byte(2'b01), ins(4'b1111, 2'd0, 2'd2), 8'h00, rx);
        cmd(id_byte(2'b01), ins(4'b1000, 2'd1, 2'd0), 8'h00, rx);
        check("R7 unknown opcodes keep wipers", 32'(wiper_pos), 32'hFCC);
        check("R7 unknown opcodes keep comparators", 32'(cmp_ctrl), 32'h1C5);
        check("R7 unknown opcode no read data", 32'(rx), 32'h0);
        cmd(id_byte(2'b01), ins(4'b1011, 2'd1, 2'd0), 8'h00, rx);
        check("R7 data register kept", 32'(rx), 32'hF1);
    endtask

    task automatic t_abort();
        logic [7:0] rx;
        logic [7:0] junk;
        frame_open();
        xfer(id_byte(2'b01), 8, junk);
        xfer(ins(4'b1010, 2'd0, 2'd0), 8, junk);
        xfer(8'h3F, 5, junk);
        frame_close();
        check("R9 partial write discarded", 32'(wiper_pos), 32'hFCC);
        cmd(id_byte(2'b01), ins(4'b1010, 2'd0, 2'd0), 8'h15, rx);
        check("R9 next frame restarts", 32'(wiper_pos), 32'hFD5);
    endtask

    task automatic t_oe();
        logic [7:0] junk;
        logic [7:0] rx;
        frame_open();
        xfer(id_byte(2'b01), 8, junk);
        xfer(ins(4'b1010, 2'd0, 2'd1), 8, junk);
        wait_clk(2);
        check("R8 oe low in write data byte", 32'(sdo_oe), 32'h0);
        frame_close();
        check("R8 aborted write keeps ch1", 32'(wiper_pos), 32'hFD5);
        frame_open();
        xfer(id_byte(2'b01), 8, junk);
        check("R8 oe low before instruction", 32'(sdo_oe), 32'h0);
        xfer(ins(4'b1011, 2'd3, 2'd2), 8, junk);
        wait_clk(2);
        check("R8 oe high in read byte", 32'(sdo_oe), 32'h1);
        xfer(8'h00, 8, rx);
        wait_clk(2);
        check("R8 oe low after read byte", 32'(sdo_oe), 32'h0);
        frame_close();
        check("R8 read value", 32'(rx), 32'hA5);
        check("R8 oe low with cs high", 32'(sdo_oe), 32'h0);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_wiper();
        t_cmp();
        t_dr();
        t_copy();
        t_bad_id();
        t_addr();
        t_opcode();
        t_abort();
        t_oe();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule